// File: doc/BRIEF.md
# Pseudo-Random Switching-Activity Generator

This block burns dynamic power on purpose. It is placed beside a protected datapath as a source of supply noise, but it shares no data with that datapath: it has its own clock, a reset and one run enable. A 19-bit Fibonacci shift-register sequence generator produces a pseudo-random bit stream. Selected bits of its state gate the clock enables of a bank of rotating 32-bit registers.

Every rotating register starts from an alternating bit pattern. Each rotation by one place therefore inverts all of its bits, and each enabled cycle gives the largest possible toggle count. The registers sit in groups of eight. Each group takes its enable from a different state bit of the generator, so the groups do not switch in lockstep.

A two-state controller (idle and running) decides whether the sequence advances. A select input picks which register of each group appears on the observation output.

Top module: `noise_toggler`

Controller states and transitions:
- `ST_IDLE`: the sequence is frozen and every group enable is low. It moves to `ST_RUN` on a clock edge at which `en` is high.
- `ST_RUN`: the sequence steps on every edge and the group enables follow the state bits. It moves to `ST_IDLE` on a clock edge at which `en` is low.

## Requirements
- R1: After reset:
  - the generator state is 19'h00001;
  - every rotating register holds 32'h55555555 (bit 0 set, alternating);
  - `running` is 0 and `grp_en` is 0.
- R2: In a cycle with `running` high, the next generator state is `{s[17:0], s[18]^s[17]^s[16]^s[13]}`. This is the recurrence of x^19+x^18+x^17+x^14+1.
- R3: The generator state is never all zeros.
- R4: `running` becomes 1 one edge after `en` is sampled high, and 0 one edge after `en` is sampled low.
- R5: While `running` is 0, the generator state and all rotating registers hold their values.
- R6: `grp_en[g]` equals `running` AND generator state bit 5*g, for each group g.
- R7: On an edge where `grp_en[g]` is 1, every register of group g rotates left by one (`{r[30:0], r[31]}`). Because of the alternating pattern, this inverts all of its bits.
- R8: On an edge where `grp_en[g]` is 0, every register of group g holds its value.
- R9: `probe[32*g +: 32]` shows register number `probe_sel` of group g, with no delay.
- R10: Starting from the seed, the recurrence of R2 returns to the seed after exactly 2^19-1 steps and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running generator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run request for the controller |
| probe_sel | input | 3 | Register index within each group shown on `probe` |
| running | output | 1 | High in state `ST_RUN` |
| lfsr_q | output | 19 | Current generator state |
| grp_en | output | 4 | Rotate enable of each group this cycle |
| probe | output | 128 | Selected register of each group, group 0 in the low bits |

## Verification
The assertions assume that `probe_sel` is held stable across an edge when they compare a group's observed register before and after that edge. The stimulus changes `probe_sel` only at falling edges, and the checks that use it compare values within one high phase. The assertions also take `en` to be a clean level sampled at the rising edge. The bench drives `en` only away from rising edges and holds it for at least one full cycle. The full period of 524287 steps is too long to clock, so the bench verifies it on its own model of the recurrence. It then matches the hardware against that model over thousands of steps.

// File: rtl/noise_pkg.sv
package noise_pkg;
    typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_RUN = 1'b1} nt_state_e;

    localparam int unsigned NT_LFSR_W = 19;
    // feedback from exponents 19,18,17,14 -> state bits 18,17,16,13
    localparam logic [NT_LFSR_W-1:0] NT_TAP_MASK = 19'h72000;
    localparam logic [NT_LFSR_W-1:0] NT_SEED     = 19'h00001;
endpackage

// File: rtl/nt_ctrl.sv
module nt_ctrl
    import noise_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic running
);
    nt_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (en)  st_d = ST_RUN;
            ST_RUN:  if (!en) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        running = (st_q == ST_RUN);
    end
endmodule

// File: rtl/nt_lfsr.sv
module nt_lfsr
    import noise_pkg::*;
#(
    parameter int unsigned W = NT_LFSR_W,
    parameter logic [W-1:0] TAPS = NT_TAP_MASK,
    parameter logic [W-1:0] SEED = NT_SEED
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] state
);
    logic fb;

    always_comb fb = ^(state & TAPS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    state <= SEED;
        else if (step) state <= {state[W-2:0], fb};
    end
endmodule

// File: rtl/nt_rot_group.sv
module nt_rot_group #(
    parameter int unsigned REG_W = 32,
    parameter int unsigned DEPTH = 8,
    localparam int unsigned SEL_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam logic [REG_W-1:0] INIT = {(REG_W/2){2'b01}}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [SEL_W-1:0] sel,
    output logic [REG_W-1:0] sel_word
);
    logic [REG_W-1:0] ring [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ring
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    ring[i] <= INIT;
            else if (step) ring[i] <= {ring[i][REG_W-2:0], ring[i][REG_W-1]};
        end
    end

    always_comb sel_word = ring[sel];
endmodule

// File: rtl/noise_toggler.sv
module noise_toggler
    import noise_pkg::*;
#(
    parameter int unsigned GROUPS     = 4,
    parameter int unsigned PER_GROUP  = 8,
    parameter int unsigned REG_W      = 32,
    parameter int unsigned TAP_STRIDE = 5,
    localparam int unsigned SEL_W = (PER_GROUP > 1) ? $clog2(PER_GROUP) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      en,
    input  logic [SEL_W-1:0]          probe_sel,
    output logic                      running,
    output logic [NT_LFSR_W-1:0]      lfsr_q,
    output logic [GROUPS-1:0]         grp_en,
    output logic [GROUPS*REG_W-1:0]   probe
);
    nt_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .running (running)
    );

    nt_lfsr u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (running),
        .state (lfsr_q)
    );

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        always_comb grp_en[g] = running & lfsr_q[(g*TAP_STRIDE) % NT_LFSR_W];

        nt_rot_group #(
            .REG_W (REG_W),
            .DEPTH (PER_GROUP)
        ) u_grp (
            .clk      (clk),
            .rst_n    (rst_n),
            .step     (grp_en[g]),
            .sel      (probe_sel),
            .sel_word (probe[g*REG_W +: REG_W])
        );
    end
endmodule

// File: rtl/noise_toggler_chk.sv
module noise_toggler_chk #(
    parameter int unsigned GROUPS = 4,
    parameter int unsigned REG_W  = 32,
    parameter int unsigned SEL_W  = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    en,
    input logic [SEL_W-1:0]        probe_sel,
    input logic                    running,
    input logic [18:0]             lfsr_q,
    input logic [GROUPS-1:0]       grp_en,
    input logic [GROUPS*REG_W-1:0] probe
);
    // R3: lock-up state never appears
    a_r3_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != 19'h0);

    // R2: recurrence while running
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> lfsr_q[18:1] == $past(lfsr_q[17:0]));

    // R4: controller follows the run request one edge later
    a_r4_follow: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> running == $past(en));

    // R5: frozen sequence while idle
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> $stable(lfsr_q));

    // R5/R6: no group enable while idle
    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> grp_en == '0);

    for (genvar g = 0; g < GROUPS; g++) begin : g_chk
        // R7: enabled edge inverts the observed register
        a_r7_invert: assert property (@(posedge clk) disable iff (!rst_n)
            grp_en[g] ##1 $stable(probe_sel) |->
            probe[g*REG_W +: REG_W] == ~$past(probe[g*REG_W +: REG_W]));
        // R8: disabled edge leaves the observed register alone
        a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !grp_en[g] ##1 $stable(probe_sel) |->
            $stable(probe[g*REG_W +: REG_W]));
    end
endmodule

bind noise_toggler noise_toggler_chk #(
    .GROUPS (GROUPS),
    .REG_W  (REG_W),
    .SEL_W  (SEL_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .probe_sel (probe_sel),
    .running   (running),
    .lfsr_q    (lfsr_q),
    .grp_en    (grp_en),
    .probe     (probe)
);

// File: tb/noise_toggler_tb.sv
module noise_toggler_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en = 1'b0;
    logic [2:0]   probe_sel = 3'd0;
    logic         running;
    logic [18:0]  lfsr_q;
    logic [3:0]   grp_en;
    logic [127:0] probe;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    logic [18:0] m_lfsr;
    logic [31:0] m_reg [4];
    logic        m_run;

    always #5 clk = ~clk;

    noise_toggler u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .probe_sel(probe_sel),
        .running(running), .lfsr_q(lfsr_q), .grp_en(grp_en), .probe(probe)
    );

    function automatic logic [18:0] m_next(input logic [18:0] s);
        return {s[17:0], s[18] ^ s[17] ^ s[16] ^ s[13]};
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // compare every output with the model (called near a falling edge)
    task automatic compare_all();
        chk("R4", {127'd0, running}, {127'd0, m_run});
        chk("R2", {109'd0, lfsr_q}, {109'd0, m_lfsr});
        for (int g = 0; g < 4; g++) begin
            chk("R6", {127'd0, grp_en[g]}, {127'd0, m_run & m_lfsr[g*5]});
            chk("R9", {96'd0, probe[g*32 +: 32]}, {96'd0, m_reg[g]});
        end
    endtask

    // one clock with en applied; the model advances exactly as the requirements say
    task automatic tick();
        if (m_run) begin
            for (int g = 0; g < 4; g++)
                if (m_lfsr[g*5]) m_reg[g] = {m_reg[g][30:0], m_reg[g][31]}; // R7
            m_lfsr = m_next(m_lfsr);                                        // R2
        end
        m_run = en;                                                          // R4
        @(posedge clk);
        @(negedge clk);
        probe_sel = probe_sel + 3'd1;
        #1;
        compare_all();
    endtask

    task automatic t_reset();
        rst_n = 1'b0; en = 1'b0;
        repeat (2) @(negedge clk);
        m_lfsr = 19'h00001; m_run = 1'b0;
        for (int g = 0; g < 4; g++) m_reg[g] = 32'h5555_5555;
        // R1: reset values
        chk("R1", {109'd0, lfsr_q}, {109'd0, 19'h00001});
        chk("R1", probe, {4{32'h5555_5555}});
        chk("R1", {123'd0, running, grp_en}, 128'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_idle_hold();
        // R5: with en low nothing moves
        en = 1'b0;
        for (int i = 0; i < 20; i++) tick();
        chk("R5", {109'd0, lfsr_q}, {109'd0, 19'h00001});
    endtask

    task automatic t_run(input int cycles);
        // R2 R6 R7 R8 R9: long run against the model
        en = 1'b1;
        for (int i = 0; i < cycles; i++) tick();
    endtask

    task automatic t_stop();
        // R4 R5: stop request, then state frozen for a while
        logic [18:0] held;
        en = 1'b0;
        tick();
        held = lfsr_q;
        for (int i = 0; i < 15; i++) tick();
        chk("R5", {109'd0, lfsr_q}, {109'd0, held});
    endtask

    task automatic t_toggle_pattern();
        // R4: en pulsed high for one cycle gives one running cycle
        en = 1'b1; tick();
        en = 1'b0; tick();
        tick();
        en = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tick();
            en = ~en;
        end
        en = 1'b0; tick(); tick();
    endtask

    task automatic t_sel_sweep();
        // R9 R8: every register index of every group shows the same idle value
        en = 1'b0;
        for (int s = 0; s < 8; s++) begin
            @(negedge clk);
            probe_sel = s[2:0];
            #1;
            for (int g = 0; g < 4; g++)
                chk("R9", {96'd0, probe[g*32 +: 32]}, {96'd0, m_reg[g]});
        end
    endtask

    task automatic t_period();
        // R10: period of the recurrence from the seed
        logic [18:0] s;
        int steps;
        s = 19'h00001;
        steps = 0;
        do begin
            s = m_next(s);
            steps++;
        end while (s != 19'h00001 && steps < 600000);
        chk("R10", 128'(steps), 128'(524287));
    endtask

    initial begin
        t_reset();
        t_idle_hold();
        t_run(3000);
        t_stop();
        t_toggle_pattern();
        t_run(1500);
        t_stop();
        t_sel_sweep();
        t_period();
        t_reset();
        t_run(50);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(10 * 150000);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule